// File: doc/BRIEF.md
# Byte-Level I2C Master Controller

This block is an I2C bus master driven through a small byte-wide register port with a 3-bit address and separate read and write strobes. Software sets a 16-bit clock divider while the core is disabled and then enables it. After that, each write to the command register runs exactly one bus operation: a START (or repeated START) followed by an address byte, a data byte write, a data byte read with a chosen acknowledge, a STOP, or a chain of these in the fixed order START, byte, STOP.

The bus lines are open-drain. The block only ever pulls SCL and SDA low through output-enable pins and reads the real line levels back. It watches the bus for START and STOP conditions from any master and keeps a busy bit. It detects lost arbitration and target NACKs, and it raises an interrupt flag when each operation ends. Only master mode is provided. Targets cannot stretch the clock, and there is no 10-bit addressing.

Top module: `i2c_byte_master`

## Requirements
- R1: Offsets are 0 divider low byte, 1 divider high byte, 2 control (bit 7 enable, bit 6 interrupt enable, bit 5 master select, other bits read 0), 3 TX data on write and RX data on read, and 4 command on write and status on read. Reads return data one cycle after the strobe. Every register resets to 0. Divider writes are ignored while enable is 1.
- R2: While enable is 0, a command write starts nothing. The in-progress bit stays 0 and SCL is never pulled low.
- R3: With divider value P (P ≥ 2), each bit takes 5·(P+1) clock cycles. Successive SCL rises inside a byte are exactly that far apart.
- R4: Command bit 7 (START) together with bit 4 (WRITE) first produces a START condition: SDA falls while SCL is high. It then sends the TX byte MSB first, and each bit is stable while SCL is high.
- R5: On a byte write, the SDA level sampled in the ninth clock is stored in status bit 7 (1 = NACK).
- R6: Command bit 5 (READ) shifts in 8 bits MSB first, and the byte appears at offset 3 when the ninth clock ends. In the ninth clock SDA is pulled low if command bit 3 is 0 (ACK) and is released if it is 1 (NACK).
- R7: Command bit 6 (STOP) makes SDA rise while SCL is high. When the operation reports completion, status bit 6 (busy) is already 0 and both output enables are 0.
- R8: Busy (status bit 6) sets on any START condition seen on the lines and clears on any STOP condition, whichever master caused it.
- R9: If SDA reads low while this master releases it and SCL is high, the operation aborts. Both output enables drop to 0, status bit 5 (arbitration lost) sets, and the interrupt flag sets. The next accepted command clears bit 5.
- R10: Status bit 0 (interrupt flag) sets when each operation ends and stays set until a command write with bit 0 set (IACK) clears it. The irq output equals the flag ANDed with the interrupt enable.
- R11: Status bit 1 (in progress) is 1 from the edge that accepts a command until the operation ends. Command writes made while it is 1 are ignored.
- R12: After reset both output enables are 0, so both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A register read returns data on the cycle after its strobe. The bench raises the strobe in one cycle and samples on the falling edge of the next cycle. The in-progress bit appears at the first read after the command write, so the bench checks it there. Flags, NACK, RX data and busy are only guaranteed once the operation reports completion, so the bench polls status until the in-progress bit drops and only then compares them. The SCL period is measured between the last two line rises of a byte, swept over divider values 2 to 5 and compared with 5·(P+1) cycles. An inline target model acknowledges its own address, returns a counting byte sequence and logs what it receives.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int DIV_W   = 16;
    localparam int PHASE_N = 5;
    localparam int PH_W    = $clog2(PHASE_N);
    localparam int BIT_N   = 9;
    localparam int CNT_W   = $clog2(BIT_N + 1);

    localparam logic [ADDR_W-1:0] OFS_DIV_LO = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_DIV_HI = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CTL    = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_CMD    = 3'd4;

    typedef enum logic [1:0] {OP_START, OP_STOP, OP_WBIT, OP_RBIT} bitop_e;
    typedef enum logic [1:0] {SQ_IDLE, SQ_START, SQ_BITS, SQ_STOP} seq_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rd;
        logic wr;
        logic ack;
    } cmd_t;

    typedef struct packed {
        logic scl_rel;
        logic sda_rel;
    } lines_t;

    function automatic cmd_t decode_cmd(input logic [DATA_W-1:0] w);
        cmd_t c;
        c.start = w[7];
        c.stop  = w[6];
        c.rd    = w[5];
        c.wr    = w[4];
        c.ack   = w[3];
        return c;
    endfunction

    function automatic lines_t line_pat(input bitop_e op, input logic [PH_W-1:0] ph,
                                        input logic b);
        lines_t l;
        l = '{scl_rel: 1'b0, sda_rel: b};
        case (op)
            OP_START: case (ph)
                3'd0:    l = '{scl_rel: 1'b0, sda_rel: 1'b1};
                3'd1:    l = '{scl_rel: 1'b1, sda_rel: 1'b1};
                3'd2,
                3'd3:    l = '{scl_rel: 1'b1, sda_rel: 1'b0};
                default: l = '{scl_rel: 1'b0, sda_rel: 1'b0};
            endcase
            OP_STOP: case (ph)
                3'd0:    l = '{scl_rel: 1'b0, sda_rel: 1'b0};
                3'd1,
                3'd2:    l = '{scl_rel: 1'b1, sda_rel: 1'b0};
                default: l = '{scl_rel: 1'b1, sda_rel: 1'b1};
            endcase
            default: l = '{scl_rel: (ph == 3'd2 || ph == 3'd3), sda_rel: b};
        endcase
        return l;
    endfunction

    function automatic logic arb_window(input bitop_e op, input logic [PH_W-1:0] ph,
                                        input logic b);
        return (op == OP_START && ph == 3'd1) ||
               (op == OP_WBIT  && b && ph == 3'd3) ||
               (op == OP_STOP  && ph == 3'd4);
    endfunction

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick
    import i2cm_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = en && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !en || restart || tick) cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end

    // R3: a nonzero divider never yields back-to-back phase ends
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && limit != '0) |=> !tick);

endmodule

// File: rtl/i2cm_linemon.sv
module i2cm_linemon (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic busy
);
    logic [1:0] scl_sync, sda_sync;
    logic       scl_d, sda_d;
    logic       start_seen, stop_seen;

    assign scl_s = scl_sync[1];
    assign sda_s = sda_sync[1];
    assign start_seen = scl_s && scl_d && sda_d && !sda_s;
    assign stop_seen  = scl_s && scl_d && !sda_d && sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
            busy     <= 1'b0;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
            if (start_seen)     busy <= 1'b1;
            else if (stop_seen) busy <= 1'b0;
        end
    end

    a_r8_busy_on_start: assert property (@(posedge clk) disable iff (rst)
        start_seen |=> busy);
    a_r8_free_on_stop: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !busy);

endmodule

// File: rtl/i2cm_phy.sv
module i2cm_phy
    import i2cm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   sda_s,
    input  logic   go,
    input  bitop_e op,
    input  logic   wbit,
    output logic   done,
    output logic   lost,
    output logic   rbit,
    output logic   scl_rel,
    output logic   sda_rel,
    output logic   active
);
    logic [PH_W-1:0] phase;
    bitop_e          op_q;
    logic            bit_q;
    logic            wbit_eff;
    logic            at_end;
    lines_t          nxt;

    assign wbit_eff = (op == OP_RBIT) ? 1'b1 : wbit;
    assign at_end   = active && tick;
    assign lost     = at_end && arb_window(op_q, phase, bit_q) && !sda_s;
    assign done     = at_end && (phase == PH_W'(PHASE_N - 1)) && !lost;
    assign nxt      = go ? line_pat(op, '0, wbit_eff)
                         : line_pat(op_q, phase + 1'b1, bit_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            phase   <= '0;
            op_q    <= OP_START;
            bit_q   <= 1'b1;
            scl_rel <= 1'b1;
            sda_rel <= 1'b1;
            rbit    <= 1'b1;
        end else if (lost) begin
            active  <= 1'b0;
            scl_rel <= 1'b1;
            sda_rel <= 1'b1;
        end else if (go) begin
            active  <= 1'b1;
            phase   <= '0;
            op_q    <= op;
            bit_q   <= wbit_eff;
            scl_rel <= nxt.scl_rel;
            sda_rel <= nxt.sda_rel;
        end else if (at_end) begin
            if (phase == PH_W'(PHASE_N - 2)) rbit <= sda_s;
            if (phase == PH_W'(PHASE_N - 1)) begin
                active <= 1'b0;
            end else begin
                phase   <= phase + 1'b1;
                scl_rel <= nxt.scl_rel;
                sda_rel <= nxt.sda_rel;
            end
        end
    end

    // R9: losing arbitration frees both lines on the next cycle
    a_r9_lines_freed: assert property (@(posedge clk) disable iff (rst)
        lost |=> (scl_rel && sda_rel && !active));
    // R4: a new bit operation starts only when the engine is free or just finishing
    a_r4_go_when_free: assert property (@(posedge clk) disable iff (rst)
        go |-> (!active || done));

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_go,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] tx,
    input  logic              phy_done,
    input  logic              phy_lost,
    input  logic              rbit,
    output logic              go,
    output bitop_e            op,
    output logic              wbit,
    output logic              fin,
    output logic              byte_end,
    output logic              wr_mode,
    output logic [DATA_W-1:0] rx_byte
);
    seq_e              state, nstate;
    cmd_t              cmd_q;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;

    assign wr_mode  = cmd_q.wr;
    assign rx_byte  = sh;
    assign byte_end = (state == SQ_BITS) && phy_done && (cnt == CNT_W'(BIT_N - 1));

    always_comb begin
        go     = 1'b0;
        op     = OP_START;
        wbit   = 1'b1;
        fin    = 1'b0;
        nstate = state;
        case (state)
            SQ_IDLE: if (cmd_go) begin
                if (cmd.start) begin
                    go = 1'b1; op = OP_START; nstate = SQ_START;
                end else if (cmd.wr || cmd.rd) begin
                    go = 1'b1; op = cmd.wr ? OP_WBIT : OP_RBIT;
                    wbit = tx[DATA_W-1]; nstate = SQ_BITS;
                end else if (cmd.stop) begin
                    go = 1'b1; op = OP_STOP; nstate = SQ_STOP;
                end else begin
                    fin = 1'b1;
                end
            end
            SQ_START: if (phy_done) begin
                if (cmd_q.wr || cmd_q.rd) begin
                    go = 1'b1; op = cmd_q.wr ? OP_WBIT : OP_RBIT;
                    wbit = sh[DATA_W-1]; nstate = SQ_BITS;
                end else if (cmd_q.stop) begin
                    go = 1'b1; op = OP_STOP; nstate = SQ_STOP;
                end else begin
                    fin = 1'b1; nstate = SQ_IDLE;
                end
            end
            SQ_BITS: if (phy_done) begin
                if (cnt < CNT_W'(DATA_W - 1)) begin
                    go = 1'b1; op = cmd_q.wr ? OP_WBIT : OP_RBIT;
                    wbit = sh[DATA_W-2];
                end else if (cnt == CNT_W'(DATA_W - 1)) begin
                    go = 1'b1; op = cmd_q.wr ? OP_RBIT : OP_WBIT;
                    wbit = cmd_q.ack;
                end else if (cmd_q.stop) begin
                    go = 1'b1; op = OP_STOP; nstate = SQ_STOP;
                end else begin
                    fin = 1'b1; nstate = SQ_IDLE;
                end
            end
            default: if (phy_done) begin
                fin = 1'b1; nstate = SQ_IDLE;
            end
        endcase
        if (phy_lost) begin
            go     = 1'b0;
            fin    = 1'b0;
            nstate = SQ_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cmd_q <= '0;
            cnt   <= '0;
            sh    <= '0;
        end else begin
            state <= nstate;
            if (state == SQ_IDLE && cmd_go) begin
                cmd_q <= cmd;
                sh    <= tx;
                cnt   <= '0;
            end else if (state == SQ_BITS && phy_done && !phy_lost
                         && cnt < CNT_W'(DATA_W)) begin
                sh  <= {sh[DATA_W-2:0], rbit};
                cnt <= cnt + 1'b1;
            end else if (state == SQ_BITS && phy_done && !phy_lost) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R7: the STOP step is entered only for commands that asked for it
    a_r7_stop_requested: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_STOP) |-> cmd_q.stop);
    // R4: a START request always begins with the START step
    a_r4_start_first: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE && cmd_go && cmd.start) |=> (state == SQ_START));

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              scl_i,
    output logic              scl_oe,
    input  logic              sda_i,
    output logic              sda_oe
);
    logic [DIV_W-1:0]  div_q;
    logic              ctl_en, ctl_ien, ctl_mst;
    logic [DATA_W-1:0] tx_q, rx_q;
    logic              st_nack, st_al, tip, iflag;

    cmd_t              wcmd;
    logic              cmd_wr, cmd_go;
    logic              tick, scl_s, sda_s, busy;
    logic              phy_go, phy_done, phy_lost, phy_rbit, phy_active;
    logic              scl_rel, sda_rel, phy_wbit;
    bitop_e            phy_op;
    logic              seq_fin, byte_end, wr_mode;
    logic [DATA_W-1:0] rx_byte;

    assign wcmd   = decode_cmd(bus_wdata);
    assign cmd_wr = bus_wr && (bus_addr == OFS_CMD);
    assign cmd_go = cmd_wr && ctl_en && !tip &&
                    (wcmd.start || wcmd.stop || wcmd.rd || wcmd.wr);
    assign irq    = iflag && ctl_ien;
    assign scl_oe = !scl_rel;
    assign sda_oe = !sda_rel;

    i2cm_tick #(.W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .en(ctl_en), .restart(cmd_go),
        .limit(div_q), .tick(tick)
    );

    i2cm_linemon u_mon (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .busy(busy)
    );

    i2cm_phy u_phy (
        .clk(clk), .rst(rst), .tick(tick), .sda_s(sda_s),
        .go(phy_go), .op(phy_op), .wbit(phy_wbit),
        .done(phy_done), .lost(phy_lost), .rbit(phy_rbit),
        .scl_rel(scl_rel), .sda_rel(sda_rel), .active(phy_active)
    );

    i2cm_seq u_seq (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd(wcmd), .tx(tx_q),
        .phy_done(phy_done), .phy_lost(phy_lost), .rbit(phy_rbit),
        .go(phy_go), .op(phy_op), .wbit(phy_wbit), .fin(seq_fin),
        .byte_end(byte_end), .wr_mode(wr_mode), .rx_byte(rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            ctl_en  <= 1'b0;
            ctl_ien <= 1'b0;
            ctl_mst <= 1'b0;
            tx_q    <= '0;
            rx_q    <= '0;
            st_nack <= 1'b0;
            st_al   <= 1'b0;
            tip     <= 1'b0;
            iflag   <= 1'b0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    OFS_DIV_LO: if (!ctl_en) div_q[7:0]  <= bus_wdata;
                    OFS_DIV_HI: if (!ctl_en) div_q[15:8] <= bus_wdata;
                    OFS_CTL: begin
                        ctl_en  <= bus_wdata[7];
                        ctl_ien <= bus_wdata[6];
                        ctl_mst <= bus_wdata[5];
                    end
                    OFS_DATA: tx_q <= bus_wdata;
                    default: ;
                endcase
            end
            if (cmd_wr && bus_wdata[0]) iflag <= 1'b0;
            if (cmd_go) begin
                tip   <= 1'b1;
                st_al <= 1'b0;
            end
            if (byte_end) begin
                if (wr_mode) st_nack <= phy_rbit;
                else         rx_q    <= rx_byte;
            end
            if (seq_fin) begin
                tip   <= 1'b0;
                iflag <= 1'b1;
            end
            if (phy_lost) begin
                tip   <= 1'b0;
                iflag <= 1'b1;
                st_al <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                OFS_DIV_LO: bus_rdata <= div_q[7:0];
                OFS_DIV_HI: bus_rdata <= div_q[15:8];
                OFS_CTL:    bus_rdata <= {ctl_en, ctl_ien, ctl_mst, 5'b0};
                OFS_DATA:   bus_rdata <= rx_q;
                OFS_CMD:    bus_rdata <= {st_nack, busy, st_al, 3'b0, tip, iflag};
                default:    bus_rdata <= '0;
            endcase
        end
    end

    a_r11_tip_raised: assert property (@(posedge clk) disable iff (rst)
        cmd_go |=> tip);
    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (!ctl_en && !tip) |=> !tip);
    a_r10_flag_on_end: assert property (@(posedge clk) disable iff (rst)
        (seq_fin || phy_lost) |=> iflag);
    a_r11_engine_only_when_busy: assert property (@(posedge clk) disable iff (rst)
        phy_active |-> tip);

endmodule

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       scl_l, sda_l;
    logic       t_drive = 1'b0, force_low = 1'b0;

    localparam logic [6:0] T_ADDR = 7'h2C;

    int nchk = 0, nfail = 0;
    int cyc = 0, rise_last = 0, rise_prev = 0;
    bit scl_seen = 0;

    assign scl_l = !scl_oe;
    assign sda_l = !(sda_oe || t_drive || force_low);

    always #2.5 clk = !clk;

    i2c_byte_master dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
        .scl_i(scl_l), .scl_oe(scl_oe), .sda_i(sda_l), .sda_oe(sda_oe)
    );

    // target model on the wired lines
    logic       tsc = 1, tsd = 1, first = 0, matched = 0, rw_next = 0, t_rd = 0, mnack = 0;
    logic [7:0] sh_in = '0, t_last = '0, t_out = '0;
    int         bc = 0, n_start = 0, n_stop = 0;

    always @(negedge clk) begin
        cyc++;
        if (scl_oe) scl_seen = 1;
        if (!tsc && scl_l) begin rise_prev = rise_last; rise_last = cyc; end
        if (tsc && scl_l && tsd && !sda_l) begin
            n_start++; bc = 0; first = 1; t_rd = 0; t_drive = 0;
        end else if (tsc && scl_l && !tsd && sda_l) begin
            n_stop++; bc = 0; first = 0; t_rd = 0; t_drive = 0;
        end else if (!tsc && scl_l) begin
            if (bc < 8) begin
                if (!t_rd) sh_in = {sh_in[6:0], sda_l};
                bc++;
            end else if (bc == 8) begin
                if (t_rd) mnack = sda_l;
                bc = 9;
            end
        end else if (tsc && !scl_l) begin
            if (bc == 8) begin
                if (!t_rd) begin
                    t_last = sh_in;
                    if (first) begin
                        matched = (sh_in[7:1] == T_ADDR);
                        rw_next = sh_in[0] && matched;
                        first = 0;
                    end else rw_next = 0;
                    t_drive = matched;
                end else t_drive = 0;
            end else if (bc == 9) begin
                bc = 0; t_drive = 0;
                if (rw_next && !t_rd) begin t_rd = 1; t_out = 8'h5A; mnack = 0; end
                else if (t_rd) t_out = t_out + 1;
                if (t_rd && !mnack) t_drive = !t_out[7];
            end else if (t_rd && !mnack && bc > 0 && bc < 8) begin
                t_drive = !t_out[7-bc];
            end
        end
        tsc = scl_l; tsd = sda_l;
        if (cyc > 150000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic wait_idle(output logic [7:0] st);
        st = 8'h02;
        for (int i = 0; i < 4000 && st[1]; i++) rd(3'd4, st);
        if (st[1]) chk("R11 completion", 1, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    logic [7:0] v;

    initial begin
        idle(3); rst = 0; idle(2);
        // reset state
        for (int a = 0; a < 5; a++) begin rd(3'(a), v); chk("R1 reset value", v, 0); end
        chk("R12 lines released after reset", {scl_oe, sda_oe}, 0);

        // divider programming and lock
        wr(3'd1, 8'h12); rd(3'd1, v); chk("R1 divider high", v, 8'h12);
        wr(3'd1, 8'h00); wr(3'd0, 8'h02); rd(3'd0, v); chk("R1 divider low", v, 2);
        wr(3'd2, 8'hE0); rd(3'd2, v); chk("R1 control readback", v, 8'hE0);
        wr(3'd0, 8'h55); rd(3'd0, v); chk("R1 divider locked while enabled", v, 2);

        // disabled core ignores commands
        wr(3'd2, 8'h00); scl_seen = 0;
        wr(3'd3, {T_ADDR, 1'b0}); wr(3'd4, 8'h90); rd(3'd4, v);
        chk("R2 no in-progress when disabled", v, 0);
        idle(40); chk("R2 no SCL activity when disabled", scl_seen, 0);

        // sweep the divider: address + data write + stop
        for (int p = 2; p <= 5; p++) begin
            wr(3'd2, 8'h00); wr(3'd0, 8'(p)); wr(3'd2, 8'hE0);
            wr(3'd3, {T_ADDR, 1'b0}); wr(3'd4, 8'h90);
            rd(3'd4, v); chk("R11 in-progress after command", v[1], 1);
            wr(3'd4, 8'h40); // ignored while in progress
            wait_idle(v);
            chk("R5 address acked status", v, 8'h41);
            chk("R10 irq with flag and enable", irq, 1);
            chk("R4 address byte on bus", t_last, {T_ADDR, 1'b0});
            chk("R3 SCL period", rise_last - rise_prev, 5 * (p + 1));
            chk("R11 ignored command left no STOP", n_stop, p - 2);
            wr(3'd4, 8'h01); rd(3'd4, v);
            chk("R10 IACK clears flag", v[0], 0); chk("R10 irq follows flag", irq, 0);
            wr(3'd3, 8'(p * 17 + 3)); wr(3'd4, 8'h10); wait_idle(v);
            chk("R4 data byte on bus", t_last, p * 17 + 3);
            chk("R5 data acked", v[7], 0);
            wr(3'd4, 8'h41); wait_idle(v);
            chk("R7 busy clear at STOP completion", v, 8'h01);
            chk("R7 lines released after STOP", {scl_oe, sda_oe}, 0);
        end
        chk("R4 START conditions counted", n_start, 4);

        // NACK on an absent address
        wr(3'd3, 8'h84); wr(3'd4, 8'h91); wait_idle(v);
        chk("R5 NACK recorded", v, 8'hC1);
        wr(3'd4, 8'h41); wait_idle(v);

        // read two bytes
        wr(3'd3, {T_ADDR, 1'b1}); wr(3'd4, 8'h91); wait_idle(v);
        chk("R5 read address acked", v[7], 0);
        wr(3'd4, 8'h21); wait_idle(v); rd(3'd3, v);
        chk("R6 first read byte", v, 8'h5A); chk("R6 ACK driven", mnack, 0);
        wr(3'd4, 8'h29); wait_idle(v); rd(3'd3, v);
        chk("R6 second read byte", v, 8'h5B); chk("R6 NACK released", mnack, 1);
        wr(3'd4, 8'h41); wait_idle(v); chk("R7 busy clear after read", v[6], 0);

        // another master holds the bus, then arbitration is lost
        wr(3'd2, 8'hA0); wr(3'd4, 8'h01);
        force_low = 1; idle(6); rd(3'd4, v);
        chk("R8 busy from foreign START", v, 8'h40);
        wr(3'd3, {T_ADDR, 1'b0}); wr(3'd4, 8'h90); wait_idle(v);
        chk("R9 arbitration lost status", v, 8'h61);
        chk("R9 lines freed", {scl_oe, sda_oe}, 0);
        chk("R10 irq masked when disabled", irq, 0);
        force_low = 0; idle(6); rd(3'd4, v);
        chk("R8 busy clear on foreign STOP", v, 8'h21);
        wr(3'd4, 8'h41); wait_idle(v);
        chk("R9 new command clears lost flag", v, 8'h01);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule